// File: doc/BRIEF.md
# Counted-Frame Serial Command Receiver

This block takes in a 16-bit command word from a three-wire synchronous serial link: an active-low select, a serial clock and a serial data line. The pins arrive with no timing relationship to the block's own fast system clock. Each pin passes through a chain of synchroniser flops and then an edge detector. While select is low, every falling edge of the serial clock shifts one data bit into a shift register, most significant bit first, and a counter tracks how many bits have arrived.

When the sixteenth bit is in, the block waits for whichever of two events comes first: the next rising edge of the serial clock, or select returning high. On that event it presents the captured word on a registered output and pulses a valid strobe for exactly one system-clock cycle. It then ignores all serial activity until select falls again. If select rises before sixteen bits have arrived, the partial word is dropped and no strobe is issued. Decoding the word and acting on it are left to the logic downstream.

Top module: `serial_word_rx`

## Requirements
- R1: While reset is high and in the first cycle after it, `word_vld_o` is 0 and `word_o` is all zeros.
- R2: While select is low and the frame is not yet full, each falling serial-clock edge shifts in the data level. The first bit received ends up in `word_o[15]` and the sixteenth in `word_o[0]`.
- R3: Once sixteen bits are held, a rising serial-clock edge causes the transfer. `word_vld_o` is 0 at the second rising system-clock edge after the pin change and 1 at the third.
- R4: Once sixteen bits are held, if select rises before the serial clock does, the transfer happens on the select rise, with the same three-edge latency.
- R5: `word_vld_o` stays high for exactly one system-clock cycle per transfer.
- R6: After a transfer, further serial-clock edges and the later rise of select cause no strobe, and `word_o` keeps its value until the next frame completes.
- R7: If select rises after fewer than sixteen bits, no strobe is issued and `word_o` is unchanged.
- R8: Serial-clock and data activity while select is high causes no strobe and leaves `word_o` unchanged.
- R9: Each falling edge of select clears the bit count and the lockout, so a full frame after an aborted or completed one is captured correctly.
- R10: `word_o` changes only in the cycle where `word_vld_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run well above the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_i | input | 1 | Frame select from the serial link, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous; sampled on serial-clock falling edges |
| word_o | output | 16 | Last completed word, registered |
| word_vld_o | output | 1 | One-cycle strobe marking a new value on `word_o` |

## Verification
A pin change reaches the edge detector after two synchroniser flops and is registered once more, so a transfer strobe is due at the third rising system-clock edge after the triggering pin change. The bench drives pins on falling system-clock edges and counts rising edges from there. It samples the strobe low after the second edge and high after the third, then low again one cycle later. Every other strobe is matched against a queue of expected words when it appears, so a strobe in a frame that should stay silent (aborted, locked out, or select high) is caught, and so is a word that comes out wrong. `word_o` is compared against the last expected word after each stimulus group, to confirm that it holds its value.

// File: rtl/swr_pkg.sv
package swr_pkg;
  // Bit positions of the serial pins inside the synchronised pin vector
  localparam int unsigned PIN_SDATA = 0;
  localparam int unsigned PIN_SCLK  = 1;
  localparam int unsigned PIN_SEL_N = 2;
  localparam int unsigned PIN_CNT   = 3;

  // Idle levels: select deasserted, serial clock high, data low
  localparam logic [PIN_CNT-1:0] PIN_IDLE = 3'b110;

  typedef struct packed {
    logic sel_rise;
    logic sel_fall;
    logic sclk_rise;
    logic sclk_fall;
  } swr_events_t;
endpackage

// File: rtl/swr_sync.sv
module swr_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/swr_edge.sv
module swr_edge #(
  parameter int unsigned WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= lvl_i;
  end

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign rise_o[b] = lvl_i[b]  & ~prev_q[b];
      assign fall_o[b] = ~lvl_i[b] &  prev_q[b];
    end
  endgenerate
endmodule

// File: rtl/swr_frame.sv
module swr_frame
  import swr_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_lvl_i,
  input  logic              din_i,
  input  swr_events_t       ev_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              locked_q;
  logic              full;
  logic              shift_en;
  logic              xfer;

  assign full     = (cnt_q == CNT_FULL);
  assign shift_en = ev_i.sclk_fall && !sel_lvl_i && !locked_q && !full && !ev_i.sel_fall;
  assign xfer     = full && !locked_q && !ev_i.sel_fall && (ev_i.sclk_rise || ev_i.sel_rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
    end else if (shift_en) begin
      shreg_q <= {shreg_q[WORD_W-2:0], din_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else if (ev_i.sel_fall) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else if (xfer) begin
      locked_q <= 1'b1;
    end else if (ev_i.sel_rise && !full) begin
      cnt_q    <= '0;
    end else if (shift_en) begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      word_vld_o <= xfer;
      if (xfer) word_o <= shreg_q;
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_FULL);

  // R5
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |=> !word_vld_o);

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (locked_q && !ev_i.sel_fall) |=> !word_vld_o);

  // R7
  abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_i.sel_rise && !full) |=> !word_vld_o);

  // R10
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !word_vld_o |-> $stable(word_o));
endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx
  import swr_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  logic [PIN_CNT-1:0] pins_raw;
  logic [PIN_CNT-1:0] pins_sync;
  logic [PIN_CNT-1:0] pins_rise;
  logic [PIN_CNT-1:0] pins_fall;
  swr_events_t        ev;

  assign pins_raw[PIN_SDATA] = sdata_i;
  assign pins_raw[PIN_SCLK]  = sclk_i;
  assign pins_raw[PIN_SEL_N] = sel_n_i;

  swr_sync #(
    .WIDTH  (PIN_CNT),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) sync_i (
    .clk    (clk),
    .rst    (rst),
    .async_i(pins_raw),
    .sync_o (pins_sync)
  );

  swr_edge #(
    .WIDTH  (PIN_CNT),
    .RST_VAL(PIN_IDLE)
  ) edge_i (
    .clk   (clk),
    .rst   (rst),
    .lvl_i (pins_sync),
    .rise_o(pins_rise),
    .fall_o(pins_fall)
  );

  assign ev.sel_rise  = pins_rise[PIN_SEL_N];
  assign ev.sel_fall  = pins_fall[PIN_SEL_N];
  assign ev.sclk_rise = pins_rise[PIN_SCLK];
  assign ev.sclk_fall = pins_fall[PIN_SCLK];

  swr_frame #(
    .WORD_W(WORD_W)
  ) frame_i (
    .clk       (clk),
    .rst       (rst),
    .sel_lvl_i (pins_sync[PIN_SEL_N]),
    .din_i     (pins_sync[PIN_SDATA]),
    .ev_i      (ev),
    .word_o    (word_o),
    .word_vld_o(word_vld_o)
  );
endmodule

// File: tb/serial_word_rx_tb_top.sv
module serial_word_rx_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sel_n = 1'b1;
  logic         sclk = 1'b1;
  logic         sdata = 1'b0;
  logic [W-1:0] word;
  logic         vld;

  int           n_chk = 0;
  int           n_bad = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] last_word = '0;
  logic         prev_vld = 1'b0;
  bit           finished = 1'b0;

  always #10 clk = ~clk;

  serial_word_rx #(.WORD_W(W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .sel_n_i(sel_n), .sclk_i(sclk), .sdata_i(sdata),
    .word_o(word), .word_vld_o(vld)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (!rst) begin
      if (vld && prev_vld)
        check(1'b0, "R5 strobe longer than one cycle", {15'b0, vld}, '0);
      if (vld && !prev_vld) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6/R7/R8 unexpected strobe", word, last_word);
        end else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          check(word === e, "R2 captured word", word, e);
        end
      end
    end
    prev_vld <= vld;
  end

  // Latency probe after a triggering pin change driven at a negedge
  task automatic probe_latency(input string req);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(vld === 1'b0, req, {15'b0, vld}, '0);
    @(posedge clk);
    @(negedge clk);
    check(vld === 1'b1, req, {15'b0, vld}, 16'h0001);
    @(negedge clk);
    check(vld === 1'b0, "R5 one-cycle strobe", {15'b0, vld}, '0);
  endtask

  // mode 0: finish with sclk rise; mode 1: finish with select rise
  task automatic frame(input logic [W-1:0] w, input int nbits, input int mode, input int extra);
    sel_n = 1'b0;
    wait_cyc(4);
    for (int i = 0; i < nbits; i++) begin
      sdata = w[W-1-i];
      wait_cyc(2);
      sclk = 1'b0;
      wait_cyc(4);
      if (i != W - 1) begin
        sclk = 1'b1;
        wait_cyc(2);
      end
    end
    if (nbits == W) begin
      exp_q.push_back(w);
      last_word = w;
      if (mode == 0) begin
        sclk = 1'b1;
        probe_latency("R3 sclk-rise transfer timing");
        for (int k = 0; k < extra; k++) begin
          sdata = ~sdata;
          wait_cyc(2); sclk = 1'b0; wait_cyc(4); sclk = 1'b1; wait_cyc(2);
        end
        sel_n = 1'b1;
        wait_cyc(8);
      end else begin
        sel_n = 1'b1;
        probe_latency("R4 select-rise transfer timing");
        wait_cyc(4);
        sclk = 1'b1;
        wait_cyc(8);
      end
      check(word === w, "R6 word held after lockout", word, w);
    end else begin
      sel_n = 1'b1;
      wait_cyc(10);
      check(word === last_word, "R7 abort leaves word", word, last_word);
    end
    check(exp_q.size() == 0, "R9 scoreboard drained", W'(exp_q.size()), '0);
  endtask

  initial begin
    wait_cyc(1);
    check(vld === 1'b0 && word === '0, "R1 reset outputs", word, '0);
    wait_cyc(4);
    rst = 1'b0;
    @(negedge clk);
    check(vld === 1'b0 && word === '0, "R1 after reset", word, '0);

    frame(16'hA5C3, W, 0, 3);
    frame(16'h1234, W, 1, 0);
    frame(16'h7777, 7, 0, 0);
    frame(16'hFFFF, W, 0, 0);

    // R8: clock and data activity with select high
    for (int k = 0; k < 20; k++) begin
      sdata = k[0];
      sclk = 1'b0; wait_cyc(3); sclk = 1'b1; wait_cyc(3);
    end
    wait_cyc(6);
    check(word === last_word, "R8 idle clocks ignored", word, last_word);

    frame(16'h0001, W, 0, 0);
    frame(16'h8000, W, 1, 0);
    frame(16'h4321, 15, 0, 0);
    frame(16'h6DB6, W, 0, 2);   // R9: full frame after an abort
    check(word === 16'h6DB6, "R9 frame after abort", word, 16'h6DB6);

    finished = 1'b1;
    summary();
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule